// File: doc/BRIEF.md
# SPI slave command FSM

This block is the serial front end of a memory-command slave. It runs on the system clock and watches an active-low select line, ss_n. While ss_n is low it samples one mosi bit per rising clock edge, MSB first, and assembles a 10-bit command word. The word goes out in parallel on cmd_word, with a one-cycle cmd_valid strobe. A downstream memory controller decodes bits [9:8] of the word: 00 is a write address, 01 is write data, 10 is a read address and 11 is a read-data request.

The first bit of each frame decides whether the frame is a write or a read. For a read, the block remembers whether a read address has already been delivered, and so whether the frame is a read-address frame or a read-data frame. In a read-data frame the controller later raises rd_valid with an 8-bit word on rd_data. The block then shifts that word out on miso, MSB first. Raising ss_n always returns the block to idle.

The state register's encoding is chosen at elaboration (sequential binary, Gray or one-hot) and does not change the behaviour seen at the ports.

Top module: `spi_cmd_slave`

## Requirements
- R1: After a synchronous active-low reset, cmd_valid is 0, cmd_word is 0 and miso is 0, and no read address is pending.
- R2: A frame begins at the rising edge that samples ss_n low while the block is idle. The next ten rising edges sample mosi, MSB first. cmd_valid is high for exactly the one cycle after the tenth sampling edge, with the word on cmd_word. cmd_word holds that value until the next word completes.
- R3: A rising edge that samples ss_n high returns the block to idle. A partial word is discarded without a cmd_valid strobe, and the next frame starts from its first bit.
- R4: mosi bits after the tenth in one frame are ignored: no further cmd_valid, and cmd_word is unchanged.
- R5: A frame whose first bit is 0 is a write frame. A frame whose first bit is 1 is a read-address frame when no read address is pending, and a read-data frame otherwise. Completing a read-address frame sets the pending flag; completing a read-data frame clears it.
- R6: In a read-data frame, the first rising edge after the word completes (the earliest is the edge that ends the cmd_valid cycle) that samples rd_valid high loads rd_data. miso then shows rd_data[7] down to rd_data[0] over the next eight cycles, one bit per cycle, and returns to 0.
- R7: rd_valid has no effect, and miso stays 0, in the following cases:
  - in write frames;
  - in read-address frames;
  - before the read-data word is complete;
  - after the eight bits of the current frame have been sent.
- R8: ss_n sampled high during read-back forces miso to 0 from the next cycle.
- R9: The encoding parameter (0 sequential binary, 1 Gray, 2 one-hot) gives the same port behaviour in every cycle.
- R10: A reset in the middle of a frame returns the block to idle, clears cmd_valid, cmd_word and miso, and clears the read-address pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling is on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial command bits from the master |
| cmd_word | output | DATA_W+2 | Last completed command word |
| cmd_valid | output | 1 | One-cycle strobe marking a new cmd_word |
| rd_data | input | DATA_W | Read data from the memory side |
| rd_valid | input | 1 | Marks rd_data as valid |
| miso | output | 1 | Serial read-back data to the master |

## Verification
The bench targets the read-pending flag: it runs alternating read frames and checks that a second read-type frame becomes read-data and a third becomes read-address again. A flag that was never set or never cleared would return data in the wrong frame, or none at all.

It drives rd_valid before the word completes, in write and read-address frames, and again after a finished read-back. A design that loaded early or reloaded late would put a stray byte on miso.

It aborts frames mid-word and mid-shift, sends extra bits beyond ten, and resets in the middle of a frame. A design that kept its bit count, re-strobed cmd_valid or kept the pending flag through reset would produce the wrong word or misclassify the next read.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WR,
    ST_RADDR,
    ST_RDATA
  } state_e;

  localparam int NUM_ST     = 5;
  localparam int ENC_BIN    = 0;
  localparam int ENC_GRAY   = 1;
  localparam int ENC_ONEHOT = 2;

  function automatic int st_width(input int enc);
    return (enc == ENC_ONEHOT) ? NUM_ST : 3;
  endfunction

  function automatic logic [NUM_ST-1:0] st_code(input int enc, input state_e s);
    logic [NUM_ST-1:0] v;
    v = NUM_ST'(s);
    case (enc)
      ENC_ONEHOT: st_code = NUM_ST'(1) << v;
      ENC_GRAY:   st_code = v ^ (v >> 1);
      default:    st_code = v;
    endcase
  endfunction

endpackage

// File: rtl/spi_cmd_fsm.sv
`timescale 1ns/1ps
module spi_cmd_fsm
  import spi_cmd_pkg::*;
#(
  parameter int ENC = ENC_BIN
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ss_n,
  input  logic   mosi,
  input  logic   word_last,
  output state_e state_o,
  output logic   rd_pend
);

  localparam int SW = st_width(ENC);

  logic [SW-1:0] cur_q;
  logic [SW-1:0] nxt_c;
  state_e        cur_s;
  state_e        nxt_s;
  logic          pend_d;

  // decode the encoded register back to a logical state
  always_comb begin
    cur_s = ST_IDLE;
    for (int i = 0; i < NUM_ST; i++) begin
      if (cur_q == SW'(st_code(ENC, state_e'(i)))) cur_s = state_e'(i);
    end
  end

  always_comb begin
    nxt_s = cur_s;
    case (cur_s)
      ST_IDLE:  if (!ss_n) nxt_s = ST_CMD;
      ST_CMD:   nxt_s = mosi ? (rd_pend ? ST_RDATA : ST_RADDR) : ST_WR;
      default:  nxt_s = cur_s;
    endcase
    if (ss_n) nxt_s = ST_IDLE;
    nxt_c = SW'(st_code(ENC, nxt_s));
  end

  always_comb begin
    pend_d = rd_pend;
    if (word_last && (cur_s == ST_RADDR)) pend_d = 1'b1;
    else if (word_last && (cur_s == ST_RDATA)) pend_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q   <= SW'(st_code(ENC, ST_IDLE));
      rd_pend <= 1'b0;
    end else begin
      cur_q   <= nxt_c;
      rd_pend <= pend_d;
    end
  end

  assign state_o = cur_s;

endmodule

// File: rtl/spi_cmd_rx.sv
`timescale 1ns/1ps
module spi_cmd_rx #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              mosi,
  output logic              word_last,
  output logic              full,
  output logic [WORD_W-1:0] cmd_word,
  output logic              cmd_valid
);

  localparam int CW = $clog2(WORD_W + 1);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [WORD_W-2:0] sh_q, sh_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              valid_q;
  logic              take;

  assign full      = (cnt_q == CW'(WORD_W));
  assign take      = shift_en && !full;
  assign word_last = take && (cnt_q == CW'(WORD_W - 1));

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    word_d = word_q;
    if (clr) begin
      cnt_d = '0;
    end else if (take) begin
      cnt_d = cnt_q + CW'(1);
      sh_d  = {sh_q[WORD_W-3:0], mosi};
    end
    if (word_last) word_d = {sh_q, mosi};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      word_q  <= word_d;
      valid_q <= word_last;
    end
  end

  assign cmd_word  = word_q;
  assign cmd_valid = valid_q;

endmodule

// File: rtl/spi_cmd_tx.sv
`timescale 1ns/1ps
module spi_cmd_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              arm,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              miso
);

  localparam int LW = $clog2(DATA_W);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [LW-1:0]     left_q, left_d;
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              miso_q, miso_d;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    busy_d = busy_q;
    done_d = done_q;
    miso_d = miso_q;
    if (clr) begin
      busy_d = 1'b0;
      done_d = 1'b0;
      left_d = '0;
      miso_d = 1'b0;
    end else if (busy_q) begin
      if (left_q != '0) begin
        miso_d = sh_q[DATA_W-1];
        sh_d   = {sh_q[DATA_W-2:0], 1'b0};
        left_d = left_q - LW'(1);
      end else begin
        miso_d = 1'b0;
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end else if (arm && rd_valid && !done_q) begin
      miso_d = rd_data[DATA_W-1];
      sh_d   = {rd_data[DATA_W-2:0], 1'b0};
      left_d = LW'(DATA_W - 1);
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      miso_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      busy_q <= busy_d;
      done_q <= done_d;
      miso_q <= miso_d;
    end
  end

  assign miso = miso_q;

endmodule

// File: rtl/spi_cmd_slave.sv
`timescale 1ns/1ps
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ENC    = ENC_BIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_n,
  input  logic              mosi,
  output logic [DATA_W+1:0] cmd_word,
  output logic              cmd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_valid,
  output logic              miso
);

  localparam int WORD_W = DATA_W + 2;

  state_e st;
  logic   rd_pend;
  logic   word_last;
  logic   full;
  logic   shift_en;
  logic   arm;

  assign shift_en = !ss_n && (st != ST_IDLE);
  assign arm      = (st == ST_RDATA) && full;

  spi_cmd_fsm #(.ENC(ENC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ss_n      (ss_n),
    .mosi      (mosi),
    .word_last (word_last),
    .state_o   (st),
    .rd_pend   (rd_pend)
  );

  spi_cmd_rx #(.WORD_W(WORD_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ss_n),
    .shift_en  (shift_en),
    .mosi      (mosi),
    .word_last (word_last),
    .full      (full),
    .cmd_word  (cmd_word),
    .cmd_valid (cmd_valid)
  );

  spi_cmd_tx #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ss_n),
    .arm      (arm),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .miso     (miso)
  );

endmodule

// File: rtl/spi_cmd_slave_chk.sv
`timescale 1ns/1ps
module spi_cmd_slave_chk
  import spi_cmd_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ss_n,
  input logic              cmd_valid,
  input logic [WORD_W-1:0] cmd_word,
  input logic              miso,
  input logic              rd_pend,
  input state_e            st
);

  logic rst_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) rst_seen <= 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!cmd_valid && !miso && (cmd_word == '0)));

  // R2
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R2
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_seen && $past(rst_n) && !cmd_valid) |-> $stable(cmd_word));

  // R3
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |=> !cmd_valid);

  // R5
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_seen && $past(rst_n) && $rose(rd_pend)) |-> ($past(st) == ST_RADDR));

  // R5
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_seen && $past(rst_n) && $fell(rd_pend)) |-> ($past(st) == ST_RDATA));

  // R7
  miso_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_seen && miso) |-> (st == ST_RDATA));

  // R8
  miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |=> !miso);

endmodule

bind spi_cmd_slave spi_cmd_slave_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ss_n      (ss_n),
  .cmd_valid (cmd_valid),
  .cmd_word  (cmd_word),
  .miso      (miso),
  .rd_pend   (rd_pend),
  .st        (st)
);

// File: tb/sim_spi_cmd_slave.sv
`timescale 1ns/1ps
module sim_spi_cmd_slave;

  logic       clk;
  logic       rst_n;
  logic       ss_n;
  logic       mosi;
  logic [7:0] rd_data;
  logic       rd_valid;

  logic [9:0] cmd_word0, cmd_word1, cmd_word2;
  logic       cmd_valid0, cmd_valid1, cmd_valid2;
  logic       miso0, miso1, miso2;

  int  n_chk;
  int  n_fail;
  int  mism;
  bit  pend;
  bit  finished;

  spi_cmd_slave #(.DATA_W(8), .ENC(0)) u0 (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .mosi(mosi),
    .cmd_word(cmd_word0), .cmd_valid(cmd_valid0),
    .rd_data(rd_data), .rd_valid(rd_valid), .miso(miso0));

  spi_cmd_slave #(.DATA_W(8), .ENC(1)) u1 (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .mosi(mosi),
    .cmd_word(cmd_word1), .cmd_valid(cmd_valid1),
    .rd_data(rd_data), .rd_valid(rd_valid), .miso(miso1));

  spi_cmd_slave #(.DATA_W(8), .ENC(2)) u2 (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .mosi(mosi),
    .cmd_word(cmd_word2), .cmd_valid(cmd_valid2),
    .rd_data(rd_data), .rd_valid(rd_valid), .miso(miso2));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // R9: every cycle, the Gray and one-hot builds must match the binary one
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if ({cmd_word1, cmd_valid1, miso1} !== {cmd_word0, cmd_valid0, miso0}) mism++;
      if ({cmd_word2, cmd_valid2, miso2} !== {cmd_word0, cmd_valid0, miso0}) mism++;
    end
  end

  // {word, data offered on rd_data}
  localparam logic [17:0] VEC [0:7] = '{
    {10'h005, 8'h77},
    {10'h1A5, 8'h00},
    {10'h25A, 8'hEE},
    {10'h300, 8'hC3},
    {10'h3FF, 8'h12},
    {10'h2F0, 8'h81},
    {10'h000, 8'hFF},
    {10'h2AA, 8'h00}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // drop select and drive ten bits; returns at the negedge that drives bit 0
  task automatic send_bits(input logic [9:0] w);
    @(negedge clk); ss_n = 1'b0;
    for (int i = 9; i >= 0; i--) begin
      @(negedge clk); mosi = w[i];
    end
  endtask

  task automatic end_frame();
    ss_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic frame(input logic [9:0] w, input logic [7:0] d, input int extra);
    bit is_rd;
    bit is_ra;
    is_rd = w[9] && pend;
    is_ra = w[9] && !pend;
    send_bits(w);
    chk(cmd_valid0 == 1'b0, "R2 strobe early", 32'(cmd_valid0), 0);
    @(negedge clk);
    chk(cmd_valid0 == 1'b1, "R2 strobe", 32'(cmd_valid0), 1);
    chk(cmd_word0 == w, "R2 word", 32'(cmd_word0), 32'(w));
    for (int k = 0; k < extra; k++) begin
      @(negedge clk); mosi = k[0];
      chk(!cmd_valid0 && cmd_word0 == w, "R4 extra bit", 32'({cmd_valid0, cmd_word0}), 32'(w));
    end
    rd_valid = 1'b1; rd_data = d;
    @(negedge clk); rd_valid = 1'b0;
    chk(cmd_valid0 == 1'b0, "R2 strobe width", 32'(cmd_valid0), 0);
    for (int b = 7; b >= 0; b--) begin
      if (is_rd) chk(miso0 == d[b], "R6 readback bit", 32'(miso0), 32'(d[b]));
      else       chk(miso0 == 1'b0, "R7 readback in non-read-data frame", 32'(miso0), 0);
      @(negedge clk);
    end
    chk(miso0 == 1'b0, "R6 miso after byte", 32'(miso0), 0);
    if (is_ra) pend = 1'b1;
    else if (is_rd) pend = 1'b0;
    end_frame();
  endtask

  initial begin
    n_chk = 0; n_fail = 0; mism = 0; pend = 1'b0; finished = 1'b0;
    rst_n = 1'b0; ss_n = 1'b1; mosi = 1'b0; rd_valid = 1'b0; rd_data = 8'h00;
    repeat (5) @(negedge clk);
    chk(cmd_valid0 == 1'b0, "R1 cmd_valid", 32'(cmd_valid0), 0);
    chk(cmd_word0 == 10'h000, "R1 cmd_word", 32'(cmd_word0), 0);
    chk(miso0 == 1'b0, "R1 miso", 32'(miso0), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 classification and R6/R7 read-back across the table
    for (int k = 0; k < 8; k++) frame(VEC[k][17:8], VEC[k][7:0], 0);

    // R4: extra bits after the word
    frame(10'h0F3, 8'h55, 4);

    // R3: abort half way through a word
    begin
      logic [9:0] prev;
      logic [9:0] part;
      prev = cmd_word0;
      part = 10'h3C0;
      @(negedge clk); ss_n = 1'b0;
      for (int i = 9; i >= 5; i--) begin
        @(negedge clk); mosi = part[i];
      end
      @(negedge clk); ss_n = 1'b1;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(!cmd_valid0 && cmd_word0 == prev, "R3 abort discards", 32'({cmd_valid0, cmd_word0}), 32'(prev));
      end
      frame(10'h14C, 8'h00, 0);
    end

    // R7: rd_valid before completion and after the byte; pend is set here
    send_bits(10'h311);
    rd_valid = 1'b1; rd_data = 8'h3C;
    @(negedge clk); rd_valid = 1'b0;
    chk(cmd_valid0 == 1'b1, "R2 strobe", 32'(cmd_valid0), 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(miso0 == 1'b0, "R7 rd_valid before completion", 32'(miso0), 0);
    end
    rd_valid = 1'b1; rd_data = 8'h96;
    @(negedge clk); rd_valid = 1'b0;
    for (int b = 7; b >= 0; b--) begin
      chk(miso0 == rd_data[b], "R6 late rd_valid", 32'(miso0), 32'(rd_data[b]));
      @(negedge clk);
    end
    chk(miso0 == 1'b0, "R6 miso after byte", 32'(miso0), 0);
    rd_valid = 1'b1; rd_data = 8'hFF;
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      chk(miso0 == 1'b0, "R7 no second read-back", 32'(miso0), 0);
    end
    rd_valid = 1'b0;
    pend = 1'b0;
    end_frame();

    // R8: select rises during read-back
    frame(10'h2C4, 8'h00, 0);
    send_bits(10'h300);
    @(negedge clk);
    rd_valid = 1'b1; rd_data = 8'hB5;
    @(negedge clk); rd_valid = 1'b0;
    chk(miso0 == 1'b1, "R6 bit7", 32'(miso0), 1);
    @(negedge clk);
    chk(miso0 == 1'b0, "R6 bit6", 32'(miso0), 0);
    @(negedge clk);
    chk(miso0 == 1'b1, "R6 bit5", 32'(miso0), 1);
    ss_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(miso0 == 1'b0, "R8 miso cut by select", 32'(miso0), 0);
    end
    pend = 1'b0;

    // R10: reset in mid-frame clears the pending flag
    frame(10'h201, 8'h00, 0);
    begin
      logic [9:0] part;
      part = 10'h3FF;
      @(negedge clk); ss_n = 1'b0;
      for (int i = 9; i >= 4; i--) begin
        @(negedge clk); mosi = part[i];
      end
    end
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(cmd_valid0 == 1'b0 && miso0 == 1'b0, "R10 outputs after reset", 32'({cmd_valid0, miso0}), 0);
    chk(cmd_word0 == 10'h000, "R10 cmd_word after reset", 32'(cmd_word0), 0);
    rst_n = 1'b1; ss_n = 1'b1;
    @(negedge clk);
    pend = 1'b0;
    frame(10'h3AB, 8'hF0, 0);
    frame(10'h3AB, 8'hF0, 0);

    chk(mism == 0, "R9 encodings agree", 32'(mism), 0);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
      $finish;
    end
  end

endmodule